// File: doc/BRIEF.md
# Reset Source Arbiter

The arbiter sits at the root of a chip's reset tree. Three sources can request a reset: an active-low external power-up pin, an active-low manual reset pin, and a single-cycle pulse from a watchdog timer. The watchdog pulse comes with a mode input that selects which class of reset it raises. The arbiter drives three reset outputs with different reach. The core output resets the processor and its interrupt controller. The peripheral output and the port output reset the on-chip peripheral registers, the I/O ports and the pin-function logic. It also keeps a one-bit class flag and emits a one-cycle release strobe.

Each pin goes through a synchroniser and then a low-width qualifier. A pin low pulse shorter than the minimum width does nothing. A qualified pin reset holds the outputs for as long as the pin stays low, and releases them once the pin goes high again. A reset raised by the watchdog holds the outputs for a fixed number of cycles. A full power-up class reset drives all three outputs, while a manual class reset drives only the core output. The pins rank above the watchdog, and the power-up pin ranks above the manual pin.

Top module: `reset_source_arbiter`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `core_rst`, `periph_rst`, `port_rst` and `rel_strobe` are 0 and `class_full` is 1.
- R2: A `pwr_rst_n` low time of at least MIN_LOW (20) clock cycles sets `core_rst`, `periph_rst` and `port_rst` to 1 and sets `class_full` to 1.
- R3: A `pwr_rst_n` low pulse shorter than MIN_LOW cycles is ignored: no output changes.
- R4: A `man_rst_n` low time of at least MIN_LOW cycles, with `pwr_rst_n` high, sets `core_rst` to 1, keeps `periph_rst` and `port_rst` at 0 and sets `class_full` to 0. A shorter low pulse is ignored.
- R5: A qualified `pwr_rst_n` wins over `man_rst_n`. This holds when both are low together, and also when the power-up pin qualifies during a manual reset, which then widens to the full class.
- R6: When the pin that holds a reset returns high, all reset outputs fall and `rel_strobe` is 1 for exactly one cycle, in the same cycle that the outputs fall.
- R7: A `wdog_ovf` pulse while idle starts a reset held for exactly WDOG_HOLD (20) cycles and then releases it. The class is full when `wdog_full` is 1 and manual when it is 0.
- R8: A `wdog_ovf` pulse that arrives while a reset is active is ignored. It neither lengthens a watchdog reset nor widens a manual reset.
- R9: A pin reset that qualifies during a watchdog hold takes over at once. The outputs stay asserted with no release in between and then follow the pin.
- R10: `class_full` keeps the class of the most recent reset until the next reset begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the arbiter itself |
| pwr_rst_n | input | 1 | External power-up reset pin, active low, asynchronous |
| man_rst_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdog_ovf | input | 1 | Watchdog overflow, one-cycle pulse, synchronous |
| wdog_full | input | 1 | Watchdog class select: 1 full class, 0 manual class |
| core_rst | output | 1 | Reset to the processor and interrupt controller |
| periph_rst | output | 1 | Reset to the on-chip peripheral registers |
| port_rst | output | 1 | Reset to the I/O ports and pin-function logic |
| class_full | output | 1 | 1 if the last reset was full class, 0 if manual |
| rel_strobe | output | 1 | One-cycle pulse when a reset is released |

## Verification
The two functions that collide are watchdog hold timing and pin qualification. The bench starts a watchdog hold while the power-up pin is already low but not yet qualified. The pin's width counter then reaches its limit in the middle of the hold. The result counts as correct only if exactly one release strobe appears, the peripheral reset rises when the pin qualifies, and the class flag reads full. A second collision pulses the watchdog in full mode during a held manual reset. There the peripheral reset must never rise and the flag must stay manual.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PIN_PWR = 2'd1,
    ST_PIN_MAN = 2'd2,
    ST_WDOG    = 2'd3
  } rsa_state_e;

  function automatic logic is_active(input rsa_state_e s);
    return s != ST_IDLE;
  endfunction
endpackage

// File: rtl/rsa_pin_qual.sv
module rsa_pin_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic level_hi,
  output logic qualified
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;

  // Synchroniser chain; idles high so a reset of the block reads as released
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign level_hi = sync_q[SYNC_STAGES-1];

  // Saturating low-width counter
  always_ff @(posedge clk) begin
    if (rst)                  low_cnt <= '0;
    else if (level_hi)        low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + CW'(1);
  end

  assign qualified = (low_cnt == LIMIT);

  // R3: qualification can only rise after a cycle of synchronised low level
  a_r3_qual_from_low: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> $past(!level_hi));
endmodule

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
#(
  parameter int WDOG_HOLD = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_qual,
  input  logic pwr_hi,
  input  logic man_qual,
  input  logic man_hi,
  input  logic wdog_ovf,
  input  logic wdog_full,
  output logic core_rst,
  output logic periph_rst,
  output logic port_rst,
  output logic class_full,
  output logic rel_strobe
);
  localparam int HW = $clog2(WDOG_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(WDOG_HOLD - 1);

  rsa_state_e    state_q, state_d;
  logic          full_q, full_d;
  logic [HW-1:0] hold_q;
  logic          hold_done;

  assign hold_done = (hold_q == HOLD_LAST);

  // Priority: power-up pin, then manual pin, then watchdog
  always_comb begin
    state_d = state_q;
    full_d  = full_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pwr_qual) begin
          state_d = ST_PIN_PWR; full_d = 1'b1;
        end else if (man_qual) begin
          state_d = ST_PIN_MAN; full_d = 1'b0;
        end else if (wdog_ovf) begin
          state_d = ST_WDOG;    full_d = wdog_full;
        end
      end
      ST_PIN_PWR: begin
        if (pwr_hi) state_d = ST_IDLE;
      end
      ST_PIN_MAN: begin
        if (pwr_qual) begin
          state_d = ST_PIN_PWR; full_d = 1'b1;
        end else if (man_hi) begin
          state_d = ST_IDLE;
        end
      end
      ST_WDOG: begin
        if (pwr_qual) begin
          state_d = ST_PIN_PWR; full_d = 1'b1;
        end else if (man_qual) begin
          state_d = ST_PIN_MAN; full_d = 1'b0;
        end else if (hold_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b1;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      full_q  <= full_d;
      if (state_q != ST_WDOG) hold_q <= '0;
      else                    hold_q <= hold_q + HW'(1);
    end
  end

  // Registered outputs taken from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst   <= 1'b0;
      periph_rst <= 1'b0;
      port_rst   <= 1'b0;
      class_full <= 1'b1;
      rel_strobe <= 1'b0;
    end else begin
      core_rst   <= is_active(state_d);
      periph_rst <= is_active(state_d) && full_d;
      port_rst   <= is_active(state_d) && full_d;
      rel_strobe <= is_active(state_q) && !is_active(state_d);
      if (is_active(state_d)) class_full <= full_d;
    end
  end

  // R6: release strobe is single and follows an active reset
  a_r6_rel_single: assert property (@(posedge clk) disable iff (rst)
    rel_strobe |=> !rel_strobe);
  a_r6_rel_after_active: assert property (@(posedge clk) disable iff (rst)
    rel_strobe |-> ($past(core_rst) && !core_rst));
  // R5: a qualified, still-low power-up pin yields the full class next cycle
  a_r5_pwr_wins: assert property (@(posedge clk) disable iff (rst)
    (pwr_qual && !pwr_hi) |=> periph_rst);
  // R4: a manual class reset never reaches the peripherals
  a_r4_man_no_periph: assert property (@(posedge clk) disable iff (rst)
    periph_rst |-> class_full);
  // R8: a held pin reset is never replaced by a watchdog hold
  a_r8_pin_not_wdog: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PIN_PWR || state_q == ST_PIN_MAN) |=> state_q != ST_WDOG);
  // R7: hold counter stays inside its window
  a_r7_hold_bounded: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WDOG) |-> (hold_q <= HOLD_LAST));
endmodule

// File: rtl/reset_source_arbiter.sv
module reset_source_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 20,
  parameter int WDOG_HOLD   = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_rst_n,
  input  logic man_rst_n,
  input  logic wdog_ovf,
  input  logic wdog_full,
  output logic core_rst,
  output logic periph_rst,
  output logic port_rst,
  output logic class_full,
  output logic rel_strobe
);
  localparam int NPINS = 2;   // index 0: power-up pin, index 1: manual pin

  logic [NPINS-1:0] pins_n, lvl_hi, qual;

  assign pins_n = {man_rst_n, pwr_rst_n};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    rsa_pin_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_LOW    (MIN_LOW)
    ) u_qual (
      .clk      (clk),
      .rst      (rst),
      .pin_n    (pins_n[g]),
      .level_hi (lvl_hi[g]),
      .qualified(qual[g])
    );
  end

  rsa_ctrl #(
    .WDOG_HOLD(WDOG_HOLD)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pwr_qual  (qual[0]),
    .pwr_hi    (lvl_hi[0]),
    .man_qual  (qual[1]),
    .man_hi    (lvl_hi[1]),
    .wdog_ovf  (wdog_ovf),
    .wdog_full (wdog_full),
    .core_rst  (core_rst),
    .periph_rst(periph_rst),
    .port_rst  (port_rst),
    .class_full(class_full),
    .rel_strobe(rel_strobe)
  );

  // R2: peripheral and port resets travel together
  a_r2_port_with_periph: assert property (@(posedge clk) disable iff (rst)
    port_rst == periph_rst);
  // R10: class flag moves only when a reset starts or widens
  a_r10_flag_stable: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> $stable(class_full));
endmodule

// File: tb/reset_source_arbiter_tb_top.sv
module reset_source_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 20;
  localparam int WDOG_HOLD  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_rst_n = 1'b1, man_rst_n = 1'b1, wdog_ovf = 1'b0, wdog_full = 1'b0;
  logic core_rst, periph_rst, port_rst, class_full, rel_strobe;

  int checks = 0, fails = 0;
  int core_cnt = 0, rel_cnt = 0;
  bit periph_seen = 0, port_seen = 0, mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_source_arbiter #(.MIN_LOW(MIN_LOW), .WDOG_HOLD(WDOG_HOLD)) dut_i (
    .clk(clk), .rst(rst), .pwr_rst_n(pwr_rst_n), .man_rst_n(man_rst_n),
    .wdog_ovf(wdog_ovf), .wdog_full(wdog_full), .core_rst(core_rst),
    .periph_rst(periph_rst), .port_rst(port_rst), .class_full(class_full),
    .rel_strobe(rel_strobe));

  always @(negedge clk) begin
    if (mon_on) begin
      core_cnt    += int'(core_rst);
      rel_cnt     += int'(rel_strobe);
      periph_seen |= periph_rst;
      port_seen   |= port_rst;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(negedge clk);
    core_cnt = 0; rel_cnt = 0; periph_seen = 0; port_seen = 0; mon_on = 1;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic pwr_pulse(input int n);
    @(negedge clk); pwr_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    pwr_rst_n = 1'b1;
  endtask

  task automatic man_pulse(input int n);
    @(negedge clk); man_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    man_rst_n = 1'b1;
  endtask

  task automatic wdog_pulse(input bit full);
    @(negedge clk); wdog_ovf = 1'b1; wdog_full = full;
    @(negedge clk); wdog_ovf = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(core_rst == 0 && periph_rst == 0 && port_rst == 0, "R1 outputs in reset",
          int'({core_rst, periph_rst, port_rst}), 0);
    check(class_full == 1 && rel_strobe == 0, "R1 flag/strobe in reset",
          int'({class_full, rel_strobe}), 2);
    rst = 1'b0;
    @(negedge clk);
    check(core_rst == 0 && rel_strobe == 0 && class_full == 1, "R1 after reset",
          int'({core_rst, rel_strobe, class_full}), 1);
  endtask

  task automatic t_pwr_short();
    mon_clear();
    pwr_pulse(MIN_LOW - 1);
    settle();
    check(core_cnt == 0, "R3 short power pulse ignored", core_cnt, 0);
    check(rel_cnt == 0, "R3 no release after short pulse", rel_cnt, 0);
  endtask

  task automatic t_pwr_min();
    mon_clear();
    pwr_pulse(MIN_LOW);
    settle();
    check(periph_seen && port_seen, "R2 minimum width qualifies",
          int'({periph_seen, port_seen}), 3);
    check(rel_cnt == 1, "R6 one release strobe", rel_cnt, 1);
    check(core_rst == 0 && class_full == 1, "R2 released, full class",
          int'({core_rst, class_full}), 1);
  endtask

  task automatic t_pwr_long();
    mon_clear();
    @(negedge clk); pwr_rst_n = 1'b0;
    repeat (30) @(negedge clk);
    check(core_rst && periph_rst && port_rst, "R2 all outputs held",
          int'({core_rst, periph_rst, port_rst}), 7);
    repeat (10) @(negedge clk);
    pwr_rst_n = 1'b1;
    settle();
    check(core_cnt == 40 - MIN_LOW, "R6 hold follows pin", core_cnt, 40 - MIN_LOW);
    check(rel_cnt == 1 && core_rst == 0, "R6 release after long pulse", rel_cnt, 1);
  endtask

  task automatic t_man();
    mon_clear();
    man_pulse(MIN_LOW - 1);
    settle();
    check(core_cnt == 0, "R4 short manual pulse ignored", core_cnt, 0);
    mon_clear();
    man_pulse(30);
    settle();
    check(core_cnt > 0 && !periph_seen && !port_seen, "R4 manual reaches core only",
          int'({core_cnt > 0, periph_seen, port_seen}), 4);
    check(class_full == 0, "R4 flag manual", int'(class_full), 0);
    repeat (50) @(negedge clk);
    check(class_full == 0, "R10 flag held", int'(class_full), 0);
  endtask

  task automatic t_both();
    mon_clear();
    @(negedge clk); pwr_rst_n = 1'b0; man_rst_n = 1'b0;
    repeat (30) @(negedge clk);
    check(periph_rst == 1 && class_full == 1, "R5 both low gives full class",
          int'({periph_rst, class_full}), 3);
    pwr_rst_n = 1'b1; man_rst_n = 1'b1;
    settle();
    mon_clear();
    @(negedge clk); man_rst_n = 1'b0;
    repeat (30) @(negedge clk);
    check(core_rst == 1 && periph_rst == 0, "R4 manual held",
          int'({core_rst, periph_rst}), 2);
    pwr_rst_n = 1'b0;
    repeat (30) @(negedge clk);
    check(periph_rst == 1 && class_full == 1, "R5 upgrade to full class",
          int'({periph_rst, class_full}), 3);
    pwr_rst_n = 1'b1; man_rst_n = 1'b1;
    settle();
    check(rel_cnt == 1 && core_rst == 0, "R6 single release after upgrade", rel_cnt, 1);
  endtask

  task automatic t_wdog();
    mon_clear();
    wdog_pulse(1'b1);
    settle();
    check(core_cnt == WDOG_HOLD, "R7 full hold length", core_cnt, WDOG_HOLD);
    check(periph_seen && rel_cnt == 1 && class_full, "R7 full class release",
          int'({periph_seen, rel_cnt == 1, class_full}), 7);
    mon_clear();
    wdog_pulse(1'b0);
    settle();
    check(core_cnt == WDOG_HOLD && !periph_seen, "R7 manual class hold",
          core_cnt, WDOG_HOLD);
    check(class_full == 0, "R7 manual class flag", int'(class_full), 0);
  endtask

  task automatic t_wdog_ignored();
    mon_clear();
    wdog_pulse(1'b0);
    repeat (8) @(negedge clk);
    wdog_pulse(1'b0);
    settle();
    check(core_cnt == WDOG_HOLD && rel_cnt == 1, "R8 no retrigger", core_cnt, WDOG_HOLD);
    mon_clear();
    @(negedge clk); man_rst_n = 1'b0;
    repeat (30) @(negedge clk);
    wdog_pulse(1'b1);
    repeat (5) @(negedge clk);
    man_rst_n = 1'b1;
    settle();
    check(!periph_seen && class_full == 0, "R8 watchdog ignored in manual",
          int'({periph_seen, class_full}), 0);
  endtask

  task automatic t_preempt();
    mon_clear();
    @(negedge clk); pwr_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    wdog_pulse(1'b0);
    repeat (5) @(negedge clk);
    check(core_rst == 1 && periph_rst == 0, "R7 watchdog manual hold running",
          int'({core_rst, periph_rst}), 2);
    repeat (25) @(negedge clk);
    check(periph_rst == 1 && class_full == 1, "R9 pin takes over hold",
          int'({periph_rst, class_full}), 3);
    pwr_rst_n = 1'b1;
    settle();
    check(rel_cnt == 1, "R9 no release between sources", rel_cnt, 1);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (5) @(negedge clk);
    t_pwr_short();
    t_pwr_min();
    t_pwr_long();
    t_man();
    t_both();
    t_wdog();
    t_wdog_ignored();
    t_preempt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule